// File: doc/BRIEF.md
# Dual-Select Static RAM

This block is a 256-word by 4-bit storage array with an 8-bit address, a 4-bit write-data input and a 4-bit read-data output. Two chip-select inputs of opposite polarity gate every access. One is active low and the other is active high, so two devices can share an address line as a bank decode without an external inverter. A read/write control picks the access direction. An output-disable input silences the data output in every mode, which lets several devices be wired onto one shared output bus.

The three-state output is modelled as a data value plus a 4-bit enable. When the enable is off, the data value is forced to zero. During a selected write with the output enabled, the output shows the incoming data, so a common input/output bus sees the written word. Writes commit on the rising clock edge. Reads are a combinational lookup of the current address. The mode decode depends only on the current inputs, so a deselect silences the output at once. Reset blocks writes and silences the output but leaves the stored words as they are.

Top module: `dsel_sram`

## Requirements
- R1: When sel_n=0, sel=1, wr_n=0 and rst=0 at a rising clock edge, din is stored at word addr, and a later read of that word returns it.
- R2: With sel_n=0, sel=1, out_off=0, wr_n=1 and rst=0, dout equals the word stored at addr and dout_en is 4'hF in the same cycle, with no clock edge needed.
- R3: With sel_n=1 or sel=0 (standby), dout_en is 4'h0, dout is 4'h0, and a clock edge changes no stored word.
- R4: In a selected write with out_off=0, dout equals the current din and dout_en is 4'hF.
- R5: With out_off=1, dout_en is 4'h0 and dout is 4'h0, whatever the selects and wr_n are.
- R6: A selected write with out_off=1 still stores din at addr.
- R7: While rst=1, no word is written and dout_en is 4'h0. Stored words survive reset unchanged.
- R8: The four bits of dout_en always share one value, so dout_en is either 4'h0 or 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous reset, active high; blocks writes and silences the output |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| out_off | input | 1 | Output disable, active high |
| wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, or echoed write data; zero when not enabled |
| dout_en | output | 4 | Per-bit output enable; 0 means high impedance |

## Verification
The output value and the enable are combinational, so they are due in the same cycle as the inputs that cause them. The bench drives each input set just after a falling edge and samples one time unit later, well before the next rising edge. A write becomes visible one rising edge later. The reference array is therefore updated only after that edge, and the readback of any written word is sampled in a later cycle. The checks also cover reset behaviour, the rule that a deselected write has no effect, and the rule that a write still lands when out_off=1.

// File: rtl/dsel_sram_pkg.sv
package dsel_sram_pkg;
  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_READ  = 2'd1,
    MD_WRITE = 2'd2
  } acc_mode_t;
endpackage

// File: rtl/dsel_mode_dec.sv
module dsel_mode_dec
  import dsel_sram_pkg::*;
(
  input  logic      rst,
  input  logic      sel_n,
  input  logic      sel,
  input  logic      out_off,
  input  logic      wr_n,
  output acc_mode_t mode,
  output logic      commit,
  output logic      drive
);
  logic picked;

  assign picked = !sel_n && sel && !rst;

  always_comb begin
    if (!picked)   mode = MD_IDLE;
    else if (wr_n) mode = MD_READ;
    else           mode = MD_WRITE;
  end

  // the output disable never blocks a write, only the drive
  assign commit = (mode == MD_WRITE);
  assign drive  = (mode != MD_IDLE) && !out_off;
endmodule

// File: rtl/dsel_array.sv
module dsel_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[addr] <= wdata;
  end

  assign rdata = words[addr];
endmodule

// File: rtl/dsel_out_stage.sv
module dsel_out_stage
  import dsel_sram_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  acc_mode_t         mode,
  input  logic              drive,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] dout_en
);
  logic [DATA_W-1:0] src;

  assign src = (mode == MD_WRITE) ? wdata : rdata;

  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    assign dout_en[b] = drive;
    assign dout[b]    = drive & src[b];
  end
endmodule

// File: rtl/dsel_sram.sv
module dsel_sram
  import dsel_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              out_off,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] dout_en
);
  acc_mode_t         mode;
  logic              commit;
  logic              drive;
  logic [DATA_W-1:0] rdata;

  dsel_mode_dec u_dec (
    .rst(rst), .sel_n(sel_n), .sel(sel), .out_off(out_off), .wr_n(wr_n),
    .mode(mode), .commit(commit), .drive(drive)
  );

  dsel_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(commit), .addr(addr), .wdata(din), .rdata(rdata)
  );

  dsel_out_stage #(.DATA_W(DATA_W)) u_out (
    .mode(mode), .drive(drive), .rdata(rdata), .wdata(din),
    .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/dsel_sram_chk.sv
module dsel_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              sel,
  input logic              out_off,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic [DATA_W-1:0] dout_en
);
  logic on;
  assign on = !sel_n && sel;

  p_standby_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !on |-> (dout_en == '0 && dout == '0));

  p_write_echo_r4: assert property (@(posedge clk) disable iff (rst)
    (on && !wr_n && !out_off) |-> (dout == din && dout_en == '1));

  p_disable_hiz_r5: assert property (@(posedge clk) disable iff (rst)
    out_off |-> (dout_en == '0 && dout == '0));

  p_en_uniform_r8: assert property (@(posedge clk) disable iff (rst)
    (dout_en == '0 || dout_en == '1));

  p_read_enable_r2: assert property (@(posedge clk) disable iff (rst)
    (on && wr_n && !out_off) |-> dout_en == '1);

  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(on && !wr_n && !rst) && on && wr_n && !out_off && addr == $past(addr))
      |-> dout == $past(din));

  always_comb begin
    if (rst) begin
      p_reset_hiz_r7: assert (dout_en == '0 || $isunknown(rst));
    end
  end
endmodule

bind dsel_sram dsel_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .out_off(out_off),
  .wr_n(wr_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
);

// File: tb/test_dsel_sram.sv
module test_dsel_sram;
  logic       clk = 0;
  logic       rst = 1;
  logic       sel_n = 1, sel = 0, out_off = 0, wr_n = 1;
  logic [7:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout, dout_en;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] refm [256];

  always #5 clk = ~clk;

  dsel_sram i_dsel_sram (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .out_off(out_off),
    .wr_n(wr_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [3:0] exp_en(logic r, logic sn, logic s, logic od);
    return (!r && !sn && s && !od) ? 4'hF : 4'h0;
  endfunction

  function automatic logic [3:0] exp_dout(logic r, logic sn, logic s, logic od,
                                          logic rw, logic [7:0] a, logic [3:0] d);
    if (exp_en(r, sn, s, od) == 4'h0) return 4'h0;
    return rw ? refm[a] : d;
  endfunction

  function automatic string tag_of(logic r, logic sn, logic s, logic od, logic rw);
    if (r) return "R7";
    if (sn || !s) return "R3";
    if (od) return "R5";
    return rw ? "R2" : "R4";
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive after a falling edge, sample 1 ns later, commit model after rising edge
  task automatic step(logic r, logic sn, logic s, logic od, logic rw,
                      logic [7:0] a, logic [3:0] d);
    string t;
    @(negedge clk);
    rst = r; sel_n = sn; sel = s; out_off = od; wr_n = rw; addr = a; din = d;
    #1;
    t = tag_of(r, sn, s, od, rw);
    check({t, " dout"}, dout, exp_dout(r, sn, s, od, rw, a, d));
    check({"R8 ", t, " dout_en"}, dout_en, exp_en(r, sn, s, od));
    @(posedge clk);
    if (!r && !sn && s && !rw) refm[a] = d;
  endtask

  task automatic read_chk(string tag, logic [7:0] a, logic [3:0] exp);
    @(negedge clk);
    rst = 0; sel_n = 0; sel = 1; out_off = 0; wr_n = 1; addr = a;
    #1;
    check(tag, dout, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // reset state: selected read while in reset stays silent
    step(1, 0, 1, 0, 1, 8'h00, 4'h0);
    // fill every word so the model matches the array
    for (int i = 0; i < 256; i++) step(0, 0, 1, 0, 0, i[7:0], 4'($urandom));
    // R1 directed: boundary addresses
    step(0, 0, 1, 0, 0, 8'h00, 4'hA);
    step(0, 0, 1, 0, 0, 8'hFF, 4'h5);
    read_chk("R1 low word", 8'h00, 4'hA);
    read_chk("R1 high word", 8'hFF, 4'h5);
    // R3 directed: deselected writes by each select leave the word alone
    step(0, 1, 1, 0, 0, 8'h10, ~refm[8'h10]);
    step(0, 0, 0, 0, 0, 8'h10, ~refm[8'h10]);
    read_chk("R3 no write", 8'h10, refm[8'h10]);
    // R6 directed: write under output disable still lands
    step(0, 0, 1, 1, 0, 8'h20, ~refm[8'h20]);
    read_chk("R6 masked write", 8'h20, refm[8'h20]);
    // R7 directed: write attempt during reset is blocked, contents kept
    step(1, 0, 1, 0, 0, 8'h30, ~refm[8'h30]);
    read_chk("R7 retained", 8'h30, refm[8'h30]);
    // random mix of every select, disable and direction combination
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] c;
      c = 5'($urandom);
      step(c[4] & c[3] & c[2], c[0], c[1], c[2], c[3], 8'($urandom), 4'($urandom));
    end
    // R1 readback sweep of the whole array
    for (int i = 0; i < 256; i++) read_chk("R1 sweep", i[7:0], refm[i]);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule